// File: doc/BRIEF.md
# Carrier Wave Modulator

This block gates a square carrier onto a baseband bit and produces the value for an output pin. The carrier is made from two separate 16-bit durations counted in base clock cycles. One sets how long the carrier stays high and the other sets how long it stays low, so the duty cycle can be anything the two counts allow.

With modulation enabled, a polarity select chooses which baseband level carries the carrier. The other level passes to the pin unchanged. With modulation disabled, the pin simply follows the baseband. Each modulated stretch of baseband is a burst, and every burst restarts the carrier at the beginning of its high part. The pin value is registered, so it shows the inputs of the previous clock cycle.

Top module: `carrier_mod`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mod_o` is 0.
- R2: With `car_en_i` at 0, `mod_o` equals the `base_i` value sampled one clock earlier, whatever the counts and the select are.
- R3: With `car_en_i` at 1 and `car_pol_i` at 0, the cycles where `base_i` is 1 are modulated and show the carrier on `mod_o`.
- R4: With `car_en_i` at 1 and `car_pol_i` at 1, the cycles where `base_i` is 0 are modulated and show the carrier on `mod_o`.
- R5: With `car_en_i` at 1, a cycle whose baseband level is not the modulated one drives `mod_o` to that baseband level.
- R6: A burst shows the carrier 1 for `hi_cnt_i` cycles, then 0 for `lo_cnt_i` cycles, and repeats that pattern. Every burst starts at the first cycle of its high part, even when the previous burst ended partway through a period.
- R7: A value of 0 in `hi_cnt_i` or `lo_cnt_i` gives that part a length of one cycle. With both at 0, the carrier toggles on every modulated cycle.
- R8: `mod_o` follows its inputs with a latency of exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_i | input | 1 | Baseband bit |
| car_en_i | input | 1 | Modulation enable |
| car_pol_i | input | 1 | 0: carrier on baseband high; 1: carrier on baseband low |
| hi_cnt_i | input | 16 | Carrier high duration in cycles (0 counts as 1) |
| lo_cnt_i | input | 16 | Carrier low duration in cycles (0 counts as 1) |
| mod_o | output | 1 | Modulated pin value |

## Verification
The bench ends a burst partway through the low part of a period and then starts a new burst. A design that resumed the old phase instead of restarting high would put a short or missing first pulse on the pin. It programs zero counts, where a design that treated 0 as a real length would freeze the carrier or wrap the counter through 65536 cycles. It runs with unequal high and low counts to catch swapped durations, and it exercises both polarity settings to catch an inverted select. It also checks that the unmodulated level is copied from the baseband rather than held at a fixed value.

// File: rtl/cmod_pkg.sv
package cmod_pkg;
   typedef enum logic {
      CAR_LOW  = 1'b0,
      CAR_HIGH = 1'b1
   } car_phase_e;
endpackage

// File: rtl/cmod_gate.sv
module cmod_gate (
   input  logic base_i,
   input  logic en_i,
   input  logic pol_i,
   output logic act_o
);
   // pol 0: modulate while base is 1; pol 1: modulate while base is 0
   assign act_o = en_i & (base_i ^ pol_i);
endmodule

// File: rtl/cmod_timer.sv
module cmod_timer
   import cmod_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic [CNT_W-1:0] high_i,
   input  logic [CNT_W-1:0] low_i,
   output car_phase_e       phase_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   car_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hi_eff, lo_eff, len;
   logic             last;

   assign hi_eff  = (high_i == '0) ? ONE : high_i;
   assign lo_eff  = (low_i  == '0) ? ONE : low_i;
   assign len     = (phase_q == CAR_HIGH) ? hi_eff : lo_eff;
   assign last    = (cnt_q >= len - ONE);
   assign phase_o = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= CAR_HIGH;
         cnt_q   <= '0;
      end else if (!act_i) begin
         phase_q <= CAR_HIGH;
         cnt_q   <= '0;
      end else if (last) begin
         phase_q <= (phase_q == CAR_HIGH) ? CAR_LOW : CAR_HIGH;
         cnt_q   <= '0;
      end else begin
         cnt_q   <= cnt_q + ONE;
      end
   end

   AST_BURST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !act_i |=> (phase_q == CAR_HIGH) && (cnt_q == '0)); // R6

   AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      act_i && phase_q == CAR_HIGH && $stable(high_i) |-> cnt_q < hi_eff); // R6

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      act_i && $past(act_i) && high_i == '0 && low_i == '0
      && $past(high_i) == '0 && $past(low_i) == '0
      |-> phase_q != $past(phase_q)); // R7
endmodule

// File: rtl/cmod_out.sv
module cmod_out #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic car_i,
   input  logic base_i,
   output logic out_o
);
   logic nxt;
   assign nxt = act_i ? car_i : base_i;

   generate
      if (OUT_REG) begin : g_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= nxt;
         end
         assign out_o = out_q;

         AST_PASS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
            !act_i |=> out_o == $past(base_i)); // R5

         AST_SHOW_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
            act_i |=> out_o == $past(car_i)); // R8
      end else begin : g_comb
         assign out_o = nxt;
      end
   endgenerate
endmodule

// File: rtl/carrier_mod.sv
module carrier_mod
   import cmod_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_i,
   input  logic             car_en_i,
   input  logic             car_pol_i,
   input  logic [CNT_W-1:0] hi_cnt_i,
   input  logic [CNT_W-1:0] lo_cnt_i,
   output logic             mod_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("carrier_mod: CNT_W must lie in 2..32");
      end
   endgenerate

   logic       act;
   car_phase_e phase;

   cmod_gate u_gate (
      .base_i (base_i),
      .en_i   (car_en_i),
      .pol_i  (car_pol_i),
      .act_o  (act)
   );

   cmod_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act),
      .high_i  (hi_cnt_i),
      .low_i   (lo_cnt_i),
      .phase_o (phase)
   );

   cmod_out #(.OUT_REG(OUT_REG)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .car_i  (phase == CAR_HIGH),
      .base_i (base_i),
      .out_o  (mod_o)
   );

   generate
      if (OUT_REG) begin : g_chk
         AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
            !car_en_i |=> mod_o == $past(base_i)); // R2
      end
   endgenerate
endmodule

// File: tb/sim_carrier_mod.sv
module sim_carrier_mod;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         base = 1'b0;
   logic         en = 1'b0;
   logic         pol = 1'b0;
   logic [W-1:0] hi = '0;
   logic [W-1:0] lo = '0;
   logic         mod;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;
   item_t sb[$];

   // reference carrier state
   logic    r_ph = 1'b1;
   int      r_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   carrier_mod u0 (
      .clk(clk), .rst_n(rst_n), .base_i(base), .car_en_i(en),
      .car_pol_i(pol), .hi_cnt_i(hi), .lo_cnt_i(lo), .mod_o(mod)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: mod_o=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: apply inputs and push the expected next-cycle output
   task automatic step(input logic b, input logic e, input logic p,
                       input int h, input int l, input string tag);
      logic act;
      int   len;
      item_t it;
      @(negedge clk);
      base = b; en = e; pol = p; hi = W'(h); lo = W'(l);
      act = e && (p ? !b : b);
      it.exp = act ? r_ph : b;
      it.tag = tag;
      sb.push_back(it);
      if (!act) begin
         r_ph = 1'b1; r_cnt = 0;
      end else begin
         len = r_ph ? ((h == 0) ? 1 : h) : ((l == 0) ? 1 : l);
         if (r_cnt + 1 >= len) begin r_ph = ~r_ph; r_cnt = 0; end
         else r_cnt++;
      end
   endtask

   // monitor: compare after each edge, away from it
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         check(mod, it.exp, it.tag);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(mod, 1'b0, "R1 in reset");
      base = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      check(mod, 1'b0, "R1 after reset");

      // R2: bypass with random baseband, odd counts and both polarities
      for (int i = 0; i < 40; i++)
         step($urandom_range(0, 1), 1'b0, i[0], 3, 5, "R2");

      // R3 + R6: pol 0, hi 3 lo 2, long high burst then low
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 3, 2, "R3");
      for (int i = 0; i < 6; i++)  step(1'b0, 1'b1, 1'b0, 3, 2, "R5");

      // R6: burst cut inside low part, restart must begin high
      for (int i = 0; i < 5; i++)  step(1'b1, 1'b1, 1'b0, 2, 4, "R6");
      for (int i = 0; i < 2; i++)  step(1'b0, 1'b1, 1'b0, 2, 4, "R5");
      for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, 2, 4, "R6");

      // R4: pol 1, carrier on baseband low, hi 1 lo 4
      for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'b1, 1, 4, "R4");
      for (int i = 0; i < 5; i++)  step(1'b1, 1'b1, 1'b1, 1, 4, "R5");
      for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1, 4, "R4");

      // R7: zero counts, one-cycle parts
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 0, 0, "R7");
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 0, 3, "R7");

      // R8: random mix, one-cycle latency tracked by scoreboard
      for (int i = 0; i < 200; i++)
         step($urandom_range(0, 1), $urandom_range(0, 3) != 0,
              $urandom_range(0, 1), $urandom_range(0, 4),
              $urandom_range(0, 4), "R8");

      // longer periods
      for (int i = 0; i < 120; i++) step(1'b1, 1'b1, 1'b0, 40, 17, "R6");

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule